// File: doc/BRIEF.md
# Security Engine Interrupt Aggregator

This block gathers nine event lines from three crypto engines into one interrupt. Two of the engines walk command rings of transfer descriptors. The third runs single DMA jobs. Each event has one bit in a flag register and a matching bit in an enable register. The block drives a single interrupt line that is high while any enabled flag is set.

Software reaches the registers over a plain word-addressed register bus with read strobe, write strobe, address, write data and registered read data. Most flags hold until software writes a 1 to them. The two event-ring-full bits do not hold: they follow the live ring-full level, and only the owning engine can clear them.

The per-descriptor done events are qualified by the descriptor's own interrupt-on-complete bit. A done event without that bit leaves the flag unchanged.

Top module: `sec_irq_agg`

## Requirements
- R1: After reset, word 0 reads 0x20180503, words 1 (enable) and 2 (flag) read 0, and `irq_o` is 0. Writes to word 0 have no effect.
- R2: Flag and enable bit positions are fixed, with the same layout in both registers:
  - 8: AES ring drained
  - 7: hash ring drained
  - 6: AES descriptor done
  - 5: hash descriptor done
  - 4: AES event ring full
  - 3: hash event ring full
  - 2: AES DMA finish
  - 1: hash DMA finish
  - 0: RSA DMA finish
- R3: A descriptor-done pulse sets its flag only when the matching interrupt-on-complete input is 1 in the same cycle.
- R4: Flag bits 8, 7, 6, 5, 2, 1 and 0 stay set until a write to word 2 has a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R5: Flag bits 4 and 3 equal the ring-full inputs sampled at the previous clock edge. Writes to word 2 do not change them.
- R6: When an event pulse and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R7: `irq_o` is registered. It is 1 in the cycle after a cycle in which some flag bit and its enable bit are both 1, and 0 otherwise.
- R8: Word 1 stores write data bits 8:0. Reads of words 1 and 2 return 0 in bits 31:9. Read data appears on `reg_rdata_o` one cycle after the read strobe.
- R9: Reads of any word address above 2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| aes_crd_i | input | 1 | AES command ring drained pulse |
| hash_crd_i | input | 1 | Hash command ring drained pulse |
| aes_trb_done_i | input | 1 | AES descriptor done pulse |
| aes_trb_ioc_i | input | 1 | Interrupt-on-complete bit of that AES descriptor |
| hash_trb_done_i | input | 1 | Hash descriptor done pulse |
| hash_trb_ioc_i | input | 1 | Interrupt-on-complete bit of that hash descriptor |
| aes_erf_i | input | 1 | AES event ring full level |
| hash_erf_i | input | 1 | Hash event ring full level |
| aes_dma_i | input | 1 | AES plain DMA finish pulse |
| hash_dma_i | input | 1 | Hash plain DMA finish pulse |
| rsa_dma_i | input | 1 | RSA DMA finish pulse |
| irq_o | output | 1 | Shared interrupt |

## Verification
The hardest case to reach from the ports is an event pulse that arrives in the same cycle as a write of 1 to the same flag bit. In that cycle the set must win over the clear. The bench drives this collision on purpose, together with a clearing write to the ring-full bits while their inputs are high. A long seeded random phase then mixes pulses, level changes, writes and reads at every word address. A bench reference model predicts each read value and each interrupt level, and every output is compared against it.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
  localparam int unsigned N_SRC = 9;

  // word indices on the register bus
  localparam int unsigned VER_IDX = 0;
  localparam int unsigned EN_IDX  = 1;
  localparam int unsigned FLG_IDX = 2;

  // bit positions, shared by the enable and flag words
  localparam int unsigned B_AES_CRD  = 8;
  localparam int unsigned B_HASH_CRD = 7;
  localparam int unsigned B_AES_TRB  = 6;
  localparam int unsigned B_HASH_TRB = 5;
  localparam int unsigned B_AES_ERF  = 4;
  localparam int unsigned B_HASH_ERF = 3;
  localparam int unsigned B_AES_DMA  = 2;
  localparam int unsigned B_HASH_DMA = 1;
  localparam int unsigned B_RSA_DMA  = 0;

  typedef logic [N_SRC-1:0] src_vec_t;

  // 1 = sticky write-1-to-clear, 0 = live mirror of a status level
  localparam src_vec_t STICKY_MASK = src_vec_t'(
      (1 << B_AES_CRD) | (1 << B_HASH_CRD) | (1 << B_AES_TRB) | (1 << B_HASH_TRB) |
      (1 << B_AES_DMA) | (1 << B_HASH_DMA) | (1 << B_RSA_DMA));
endpackage

// File: rtl/sec_irq_flags.sv
module sec_irq_flags
  import sec_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t ev_i,    // pulses on sticky bits, levels on mirror bits
  input  src_vec_t clr_i,
  output src_vec_t flag_o
);
  src_vec_t flag_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      // set beats a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q[i] <= 1'b0;
        else         flag_q[i] <= ev_i[i] | (flag_q[i] & ~clr_i[i]);
      end
    end else begin : g_mirror
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q[i] <= 1'b0;
        else         flag_q[i] <= ev_i[i];
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sec_irq_regif.sv
module sec_irq_regif
  import sec_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = DATA_W'(32'h2018_0503)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  src_vec_t          flag_i,
  output src_vec_t          en_o,
  output src_vec_t          clr_o
);
  localparam logic [ADDR_W-1:0] A_VER = ADDR_W'(VER_IDX);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_IDX);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(FLG_IDX);

  src_vec_t          en_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:N_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           en_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_EN) en_q <= reg_wdata_i[N_SRC-1:0];
  end

  // only sticky bits respond to a clearing write
  assign clr_o = (reg_wr_i && reg_addr_i == A_FLG) ?
                 (reg_wdata_i[N_SRC-1:0] & STICKY_MASK) : '0;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      A_VER:   rd_mux = VERSION;
      A_EN:    rd_mux = DATA_W'(en_q);
      A_FLG:   rd_mux = DATA_W'(flag_i);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign en_o        = en_q;
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/sec_irq_out.sv
module sec_irq_out
  import sec_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t flag_i,
  input  src_vec_t en_i,
  output logic     irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sec_irq_agg.sv
module sec_irq_agg
  import sec_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              aes_crd_i,
  input  logic              hash_crd_i,
  input  logic              aes_trb_done_i,
  input  logic              aes_trb_ioc_i,
  input  logic              hash_trb_done_i,
  input  logic              hash_trb_ioc_i,
  input  logic              aes_erf_i,
  input  logic              hash_erf_i,
  input  logic              aes_dma_i,
  input  logic              hash_dma_i,
  input  logic              rsa_dma_i,
  output logic              irq_o
);
  src_vec_t ev_w, clr_w, flag_w, en_w;

  always_comb begin
    ev_w             = '0;
    ev_w[B_AES_CRD]  = aes_crd_i;
    ev_w[B_HASH_CRD] = hash_crd_i;
    ev_w[B_AES_TRB]  = aes_trb_done_i & aes_trb_ioc_i;
    ev_w[B_HASH_TRB] = hash_trb_done_i & hash_trb_ioc_i;
    ev_w[B_AES_ERF]  = aes_erf_i;
    ev_w[B_HASH_ERF] = hash_erf_i;
    ev_w[B_AES_DMA]  = aes_dma_i;
    ev_w[B_HASH_DMA] = hash_dma_i;
    ev_w[B_RSA_DMA]  = rsa_dma_i;
  end

  sec_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .flag_i      (flag_w),
    .en_o        (en_w),
    .clr_o       (clr_w)
  );

  sec_irq_flags i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev_w),
    .clr_i  (clr_w),
    .flag_o (flag_w)
  );

  sec_irq_out i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_w),
    .en_i   (en_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/sec_irq_agg_chk.sv
module sec_irq_agg_chk
  import sec_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              aes_crd_i,
  input logic              aes_trb_done_i,
  input logic              aes_trb_ioc_i,
  input logic              aes_erf_i,
  input logic              rsa_dma_i,
  input logic              irq_o,
  input src_vec_t          flag_w,
  input src_vec_t          en_w
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_IDX);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(FLG_IDX);

  p_crd_pos_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aes_crd_i |=> flag_w[B_AES_CRD]);

  p_trb_ioc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aes_trb_done_i && aes_trb_ioc_i) |=> flag_w[B_AES_TRB]);

  p_trb_noioc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_w[B_AES_TRB] && !aes_trb_ioc_i) |=> !flag_w[B_AES_TRB]);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == A_FLG) |=> !$fell(flag_w[B_RSA_DMA]));

  p_erf_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_w[B_AES_ERF] == $past(aes_erf_i)));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsa_dma_i |=> flag_w[B_RSA_DMA]);

  p_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(flag_w & en_w))));

  p_rsv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && (reg_addr_i == A_EN || reg_addr_i == A_FLG))
    |=> (reg_rdata_o[DATA_W-1:N_SRC] == '0));

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i > A_FLG) |=> (reg_rdata_o == '0));
endmodule

bind sec_irq_agg sec_irq_agg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_sec_irq_agg.sv
module test_sec_irq_agg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] VER    = 32'h2018_0503;
  localparam logic [8:0]  STICKY = 9'h1E7; // bits 8,7,6,5,2,1,0

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic              reg_rd = 0, reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic aes_crd = 0, hash_crd = 0, aes_done = 0, aes_ioc = 0, hash_done = 0, hash_ioc = 0;
  logic aes_erf = 0, hash_erf = 0, aes_dma = 0, hash_dma = 0, rsa_dma = 0;
  logic irq;

  sec_irq_agg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sec_irq_agg (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .aes_crd_i(aes_crd), .hash_crd_i(hash_crd),
    .aes_trb_done_i(aes_done), .aes_trb_ioc_i(aes_ioc),
    .hash_trb_done_i(hash_done), .hash_trb_ioc_i(hash_ioc),
    .aes_erf_i(aes_erf), .hash_erf_i(hash_erf),
    .aes_dma_i(aes_dma), .hash_dma_i(hash_dma), .rsa_dma_i(rsa_dma),
    .irq_o(irq)
  );

  int n_cmp = 0, n_err = 0;
  bit done = 0, chk_on = 0;
  string rd_tag = "R1";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a, logic [8:0] f, logic [8:0] e);
    case (a)
      ADDR_W'(0): return VER;
      ADDR_W'(1): return {23'b0, e};
      ADDR_W'(2): return {23'b0, f};
      default:    return 32'h0;
    endcase
  endfunction

  // reference model built from the requirements
  logic [8:0]  m_flag, m_en;
  logic        m_irq, m_rd_v;
  logic [31:0] m_rdata;
  string       m_tag;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag <= '0; m_en <= '0; m_irq <= 1'b0; m_rd_v <= 1'b0; m_rdata <= '0; m_tag <= "R1";
    end else begin
      logic [8:0] set_v, clr_v, live_v;
      set_v  = {aes_crd, hash_crd, aes_done & aes_ioc, hash_done & hash_ioc,
                2'b00, aes_dma, hash_dma, rsa_dma};
      live_v = {4'b0, aes_erf, hash_erf, 3'b0};
      clr_v  = (reg_wr && reg_addr == ADDR_W'(2)) ? (reg_wdata[8:0] & STICKY) : '0;
      m_flag <= (((m_flag & ~clr_v) | set_v) & STICKY) | live_v;
      if (reg_wr && reg_addr == ADDR_W'(1)) m_en <= reg_wdata[8:0];
      m_irq  <= |(m_flag & m_en);
      m_rd_v <= reg_rd;
      m_tag  <= rd_tag;
      if (reg_rd) m_rdata <= exp_read(reg_addr, m_flag, m_en);
    end
  end

  always @(negedge clk) begin
    if (rst_ni && chk_on) begin
      chk("R7 irq", {31'b0, irq}, {31'b0, m_irq});
      if (m_rd_v) chk(m_tag, reg_rdata, m_rdata);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, string tag);
    reg_rd = 1; reg_addr = a; rd_tag = tag;
    step();
    reg_rd = 0;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic quiet();
    {aes_crd, hash_crd, aes_done, aes_ioc, hash_done, hash_ioc, aes_dma, hash_dma, rsa_dma} = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk_on = 1;
    // R1: reset values and version write ignored
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1");
    wr(0, 32'hFFFF_FFFF); rd(0, "R1");
    // R8: enable storage, upper bits read zero
    wr(1, 32'hFFFF_FFFF); rd(1, "R8");
    wr(1, 32'h0000_0000);
    // R2: each source lands on its own bit
    aes_crd = 1; step(); quiet(); rd(2, "R2");
    hash_dma = 1; step(); quiet(); rd(2, "R2");
    wr(2, 32'h1FF); rd(2, "R2");
    // R3: descriptor done without and with interrupt-on-complete
    aes_done = 1; aes_ioc = 0; hash_done = 1; hash_ioc = 0; step(); quiet();
    rd(2, "R3");
    hash_done = 1; hash_ioc = 1; step(); quiet(); rd(2, "R3");
    // R4: a write of zero keeps the bit, a write of one clears it
    rsa_dma = 1; step(); quiet();
    wr(2, 32'h0); rd(2, "R4");
    wr(2, 32'h1); rd(2, "R4");
    // R5: ring-full bits follow the level and ignore clearing writes
    aes_erf = 1; hash_erf = 1; step();
    wr(2, 32'h18); rd(2, "R5");
    aes_erf = 0; step(); rd(2, "R5");
    hash_erf = 0; step(); rd(2, "R5");
    // R6: set and clear collide on the same bit
    wr(2, 32'h1FF);
    rsa_dma = 1; aes_crd = 1; reg_wr = 1; reg_addr = 2; reg_wdata = 32'h101;
    step(); reg_wr = 0; quiet();
    rd(2, "R6");
    // R7: interrupt follows enabled flags
    wr(1, 32'h001); step(); step();
    wr(1, 32'h000); step(); step();
    wr(2, 32'h1FF);
    // R9: unmapped words
    rd(3, "R9"); rd(4'hF, "R9"); rd(4'h8, "R9");

    // seeded random phase
    for (int i = 0; i < 4000; i++) begin
      aes_crd   = ($urandom % 16) == 0;
      hash_crd  = ($urandom % 16) == 0;
      aes_done  = ($urandom % 8) == 0;
      aes_ioc   = $urandom % 2;
      hash_done = ($urandom % 8) == 0;
      hash_ioc  = $urandom % 2;
      aes_dma   = ($urandom % 12) == 0;
      hash_dma  = ($urandom % 12) == 0;
      rsa_dma   = ($urandom % 12) == 0;
      if (($urandom % 20) == 0) aes_erf = ~aes_erf;
      if (($urandom % 20) == 0) hash_erf = ~hash_erf;
      reg_rd    = ($urandom % 3) == 0;
      reg_wr    = !reg_rd && (($urandom % 4) == 0);
      reg_addr  = (($urandom % 8) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom % 3);
      reg_wdata = $urandom;
      case (reg_addr)
        ADDR_W'(0): rd_tag = "R1";
        ADDR_W'(1): rd_tag = "R8";
        ADDR_W'(2): rd_tag = "R4";
        default:    rd_tag = "R9";
      endcase
      step();
    end
    reg_rd = 0; reg_wr = 0; quiet();
    step(); step();
    done = 1;
    summary();
    $finish;
  end
endmodule